// File: doc/BRIEF.md
# Pipeline Hazard Stall and Forward Control

This block is the hazard controller of a five-stage in-order pipeline with fetch, decode, execute, memory and writeback stages. It looks at the two register sources of the instruction in decode and at the destination identifiers of the instructions in execute, memory and writeback. It also takes a load flag and a branch-mispredict flag for the instruction in execute. From these it produces one hold (stall) bit and one bubble bit for each sequential element: the PC and the four stage registers. It also produces a select code per decode operand that tells the datapath where to take that operand from.

Every control output is combinational and describes what the registers do at the coming clock edge. Three mechanisms feed one per-register vector: load-use stalling, nearest-producer forwarding, and the flush of wrong-path instructions after a mispredict. A parameter picks between the forwarding variant and a variant without forwarding. The second variant holds a dependent instruction in decode until its producer has left writeback.

Top module: `hz_pipe_ctl`

## Requirements
- R1: With forwarding on and no mispredict, when the execute instruction is a load whose load destination equals a decode source, the PC and fetch/decode register are held (ctl_stall = 5'b00011) and the decode/execute register is bubbled (ctl_bubble = 5'b00100). Bit order is PC=0, fetch/decode=1, decode/execute=2, execute/memory=3, memory/writeback=4.
- R2: When e_mispredict is high, the fetch/decode and decode/execute registers are bubbled (ctl_bubble = 5'b00110) and nothing is held (ctl_stall = 0). The wrong-path instruction in decode therefore enters execute as a nop and cannot write the condition codes.
- R3: When a mispredict and a load-use hazard occur together, the mispredict result of R2 is produced and the load-use stall is dropped.
- R4: No register has its stall and bubble bits set at the same time, and the execute/memory and memory/writeback registers are never stalled or bubbled.
- R5: With forwarding on, each operand select uses the nearest producer in this order: execute ALU result (code 1), memory-stage load data (code 2), memory-stage ALU result (code 3), writeback-stage load data (code 4), writeback-stage ALU result (code 5). If none matches, the register file is used (code 0).
- R6: Within one stage, a load destination match takes priority over an ALU destination match.
- R7: Register code 15 means "no register". A source holding 15 never matches, never causes a stall and always selects code 0.
- R8: With forwarding off (FWD_EN=0), a decode source that equals any valid destination in execute, memory or writeback gives ctl_stall = 5'b00011 and ctl_bubble = 5'b00100, and both selects stay 0.
- R9: When no source matches any destination and there is no mispredict, all stall and bubble bits are 0 and both selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_src_a | input | RW | First register source of the decode instruction |
| d_src_b | input | RW | Second register source of the decode instruction |
| e_dst_alu | input | RW | ALU destination of the execute instruction |
| e_dst_mem | input | RW | Load destination of the execute instruction |
| e_is_load | input | 1 | Execute instruction reads memory |
| e_mispredict | input | 1 | Branch in execute was mispredicted |
| m_dst_alu | input | RW | ALU destination of the memory-stage instruction |
| m_dst_mem | input | RW | Load destination of the memory-stage instruction |
| w_dst_alu | input | RW | ALU destination of the writeback instruction |
| w_dst_mem | input | RW | Load destination of the writeback instruction |
| ctl_stall | output | 5 | Hold bits for the next edge, bit 0 = PC |
| ctl_bubble | output | 5 | Nop-insert bits for the next edge, bit 0 = PC |
| fwd_sel_a | output | 3 | Source select for operand A |
| fwd_sel_b | output | 3 | Source select for operand B |

## Verification
The case that is hardest to reach from the ports is a collision of hazards. One example is a load-use match present in the same cycle as a mispredict. Another is one source register named by producers in several stages at once, where only the nearest may win. The directed tasks build each collision on purpose and then remove the nearest producer one stage at a time, so every priority level is reached. A second instance built without forwarding sees the same stimulus, so the two variants can be compared on the same dependences.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int NSTG   = 5;
  localparam int IDX_PC = 0;
  localparam int IDX_FD = 1;
  localparam int IDX_DE = 2;
  localparam int IDX_EM = 3;
  localparam int IDX_MW = 4;

  typedef enum logic [2:0] {
    FS_RF     = 3'd0,
    FS_E_ALU  = 3'd1,
    FS_M_LOAD = 3'd2,
    FS_M_ALU  = 3'd3,
    FS_W_LOAD = 3'd4,
    FS_W_ALU  = 3'd5
  } fwd_src_e;
endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
#(
  parameter int RW      = 4,
  parameter int NONE_ID = 15
) (
  input  logic [RW-1:0] src,
  input  logic [RW-1:0] e_alu,
  input  logic [RW-1:0] m_load,
  input  logic [RW-1:0] m_alu,
  input  logic [RW-1:0] w_load,
  input  logic [RW-1:0] w_alu,
  output fwd_src_e      sel
);
  localparam logic [RW-1:0] NONE = RW'(NONE_ID);

  logic valid;
  assign valid = (src != NONE);

  // nearest producer first; load data before ALU data within a stage
  always_comb begin
    sel = FS_RF;
    if (valid) begin
      if      (src == e_alu)  sel = FS_E_ALU;
      else if (src == m_load) sel = FS_M_LOAD;
      else if (src == m_alu)  sel = FS_M_ALU;
      else if (src == w_load) sel = FS_W_LOAD;
      else if (src == w_alu)  sel = FS_W_ALU;
    end
  end
endmodule

// File: rtl/hz_dep_detect.sv
module hz_dep_detect #(
  parameter int RW      = 4,
  parameter int NONE_ID = 15,
  parameter bit FWD_EN  = 1'b1
) (
  input  logic [RW-1:0] src_a,
  input  logic [RW-1:0] src_b,
  input  logic          e_is_load,
  input  logic [RW-1:0] e_dst_alu,
  input  logic [RW-1:0] e_dst_mem,
  input  logic [RW-1:0] m_dst_alu,
  input  logic [RW-1:0] m_dst_mem,
  input  logic [RW-1:0] w_dst_alu,
  input  logic [RW-1:0] w_dst_mem,
  output logic          need_hold
);
  localparam logic [RW-1:0] NONE = RW'(NONE_ID);

  function automatic logic hit(input logic [RW-1:0] s, input logic [RW-1:0] d);
    return (s != NONE) && (s == d);
  endfunction

  function automatic logic hit2(input logic [RW-1:0] d);
    return hit(src_a, d) || hit(src_b, d);
  endfunction

  generate
    if (FWD_EN) begin : g_fwd
      // only a load in execute is too late to forward
      assign need_hold = e_is_load && hit2(e_dst_mem);
    end else begin : g_nofwd
      // wait until every producer has left writeback
      assign need_hold = hit2(e_dst_alu) || (e_is_load && hit2(e_dst_mem)) ||
                         hit2(m_dst_alu) || hit2(m_dst_mem) ||
                         hit2(w_dst_alu) || hit2(w_dst_mem);
    end
  endgenerate
endmodule

// File: rtl/hz_ctl_merge.sv
module hz_ctl_merge
  import hz_pkg::*;
(
  input  logic            need_hold,
  input  logic            mispredict,
  output logic [NSTG-1:0] stall,
  output logic [NSTG-1:0] bubble
);
  always_comb begin
    stall  = '0;
    bubble = '0;
    if (mispredict) begin
      // squash wrong path: both front registers take nops
      bubble[IDX_FD] = 1'b1;
      bubble[IDX_DE] = 1'b1;
    end else if (need_hold) begin
      stall[IDX_PC]  = 1'b1;
      stall[IDX_FD]  = 1'b1;
      bubble[IDX_DE] = 1'b1;
    end
  end
endmodule

// File: rtl/hz_pipe_ctl.sv
module hz_pipe_ctl
  import hz_pkg::*;
#(
  parameter int RW      = 4,
  parameter int NONE_ID = 15,
  parameter bit FWD_EN  = 1'b1
) (
  input  logic [RW-1:0]   d_src_a,
  input  logic [RW-1:0]   d_src_b,
  input  logic [RW-1:0]   e_dst_alu,
  input  logic [RW-1:0]   e_dst_mem,
  input  logic            e_is_load,
  input  logic            e_mispredict,
  input  logic [RW-1:0]   m_dst_alu,
  input  logic [RW-1:0]   m_dst_mem,
  input  logic [RW-1:0]   w_dst_alu,
  input  logic [RW-1:0]   w_dst_mem,
  output logic [NSTG-1:0] ctl_stall,
  output logic [NSTG-1:0] ctl_bubble,
  output logic [2:0]      fwd_sel_a,
  output logic [2:0]      fwd_sel_b
);
  logic need_hold;

  hz_dep_detect #(.RW(RW), .NONE_ID(NONE_ID), .FWD_EN(FWD_EN)) u_det (
    .src_a(d_src_a), .src_b(d_src_b), .e_is_load(e_is_load),
    .e_dst_alu(e_dst_alu), .e_dst_mem(e_dst_mem),
    .m_dst_alu(m_dst_alu), .m_dst_mem(m_dst_mem),
    .w_dst_alu(w_dst_alu), .w_dst_mem(w_dst_mem),
    .need_hold(need_hold)
  );

  hz_ctl_merge u_merge (
    .need_hold(need_hold), .mispredict(e_mispredict),
    .stall(ctl_stall), .bubble(ctl_bubble)
  );

  logic [RW-1:0] srcs [2];
  fwd_src_e      sels [2];
  assign srcs[0] = d_src_a;
  assign srcs[1] = d_src_b;

  generate
    for (genvar i = 0; i < 2; i++) begin : g_op
      if (FWD_EN) begin : g_pick
        hz_fwd_pick #(.RW(RW), .NONE_ID(NONE_ID)) u_pick (
          .src(srcs[i]), .e_alu(e_dst_alu), .m_load(m_dst_mem),
          .m_alu(m_dst_alu), .w_load(w_dst_mem), .w_alu(w_dst_alu),
          .sel(sels[i])
        );
      end else begin : g_rf
        assign sels[i] = FS_RF;
      end
    end
  endgenerate

  assign fwd_sel_a = sels[0];
  assign fwd_sel_b = sels[1];
endmodule

// File: rtl/hz_pipe_ctl_chk.sv
module hz_pipe_ctl_chk #(
  parameter int RW      = 4,
  parameter int NONE_ID = 15,
  parameter bit FWD_EN  = 1'b1
) (
  input logic [RW-1:0] d_src_a,
  input logic [RW-1:0] d_src_b,
  input logic [RW-1:0] e_dst_alu,
  input logic [RW-1:0] e_dst_mem,
  input logic          e_is_load,
  input logic          e_mispredict,
  input logic [4:0]    ctl_stall,
  input logic [4:0]    ctl_bubble,
  input logic [2:0]    fwd_sel_a,
  input logic [2:0]    fwd_sel_b
);
  localparam logic [RW-1:0] NONE = RW'(NONE_ID);

  always_comb begin
    a_r2_mispredict_flush: assert (!e_mispredict ||
      (ctl_bubble == 5'b00110 && ctl_stall == 5'b00000))
      else $error("R2 mispredict flush wrong");
    a_r1_load_use_hold: assert (!(FWD_EN && !e_mispredict && e_is_load &&
      e_dst_mem != NONE && (e_dst_mem == d_src_a || e_dst_mem == d_src_b)) ||
      (ctl_stall == 5'b00011 && ctl_bubble == 5'b00100))
      else $error("R1 load-use hold wrong");
    a_r4_no_overlap: assert ((ctl_stall & ctl_bubble) == 5'b00000 &&
      ctl_stall[4:3] == 2'b00 && ctl_bubble[4:3] == 2'b00)
      else $error("R4 stall/bubble overlap");
    a_r7_none_rf_a: assert (d_src_a != NONE || fwd_sel_a == 3'd0)
      else $error("R7 none source forwarded on A");
    a_r7_none_rf_b: assert (d_src_b != NONE || fwd_sel_b == 3'd0)
      else $error("R7 none source forwarded on B");
    a_r5_exec_match: assert (fwd_sel_a != 3'd1 || e_dst_alu == d_src_a)
      else $error("R5 execute select without match");
    a_r8_nofwd_rf: assert (FWD_EN || (fwd_sel_a == 3'd0 && fwd_sel_b == 3'd0))
      else $error("R8 forward select in no-forward variant");
  end
endmodule

bind hz_pipe_ctl hz_pipe_ctl_chk #(.RW(RW), .NONE_ID(NONE_ID), .FWD_EN(FWD_EN)) u_chk (
  .d_src_a(d_src_a), .d_src_b(d_src_b), .e_dst_alu(e_dst_alu),
  .e_dst_mem(e_dst_mem), .e_is_load(e_is_load), .e_mispredict(e_mispredict),
  .ctl_stall(ctl_stall), .ctl_bubble(ctl_bubble),
  .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b)
);

// File: tb/sim_hz_pipe_ctl.sv
module sim_hz_pipe_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [3:0] sa, sb, ea, em, ma, mm, wa, wm;
  logic       eld, mis;
  logic [4:0] st0, bu0, st1, bu1;
  logic [2:0] fa0, fb0, fa1, fb1;
  int n_chk = 0;
  int n_bad = 0;

  hz_pipe_ctl u0 (
    .d_src_a(sa), .d_src_b(sb), .e_dst_alu(ea), .e_dst_mem(em),
    .e_is_load(eld), .e_mispredict(mis), .m_dst_alu(ma), .m_dst_mem(mm),
    .w_dst_alu(wa), .w_dst_mem(wm), .ctl_stall(st0), .ctl_bubble(bu0),
    .fwd_sel_a(fa0), .fwd_sel_b(fb0)
  );

  hz_pipe_ctl #(.FWD_EN(1'b0)) u1 (
    .d_src_a(sa), .d_src_b(sb), .e_dst_alu(ea), .e_dst_mem(em),
    .e_is_load(eld), .e_mispredict(mis), .m_dst_alu(ma), .m_dst_mem(mm),
    .w_dst_alu(wa), .w_dst_mem(wm), .ctl_stall(st1), .ctl_bubble(bu1),
    .fwd_sel_a(fa1), .fwd_sel_b(fb1)
  );

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic clear();
    @(negedge clk);
    sa = 4'hF; sb = 4'hF; ea = 4'hF; em = 4'hF; ma = 4'hF; mm = 4'hF;
    wa = 4'hF; wm = 4'hF; eld = 1'b0; mis = 1'b0;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic t_idle();
    clear(); sa = 4'd1; sb = 4'd2; ea = 4'd3; ma = 4'd4; wm = 4'd5; settle();
    chk("R9 stall", st0, 5'b00000);
    chk("R9 bubble", bu0, 5'b00000);
    chk("R9 sel a", {2'b0, fa0}, 5'd0);
    chk("R9 sel b nofwd", {2'b0, fb1}, 5'd0);
    chk("R9 stall nofwd", st1, 5'b00000);
  endtask

  task automatic t_load_use();
    clear(); sa = 4'd3; eld = 1'b1; em = 4'd3; settle();
    chk("R1 stall a", st0, 5'b00011);
    chk("R1 bubble a", bu0, 5'b00100);
    clear(); sb = 4'd6; eld = 1'b1; em = 4'd6; settle();
    chk("R1 stall b", st0, 5'b00011);
    chk("R1 bubble b", bu0, 5'b00100);
    // one cycle later the load sits in memory: forward its data, no hold
    clear(); sb = 4'd6; mm = 4'd6; settle();
    chk("R1 after-stall stall", st0, 5'b00000);
    chk("R1 after-stall sel b", {2'b0, fb0}, 5'd2);
    // load destination not used by decode: no hold
    clear(); sa = 4'd2; eld = 1'b1; em = 4'd9; settle();
    chk("R1 no-match stall", st0, 5'b00000);
  endtask

  task automatic t_mispredict();
    clear(); mis = 1'b1; sa = 4'd1; settle();
    chk("R2 stall", st0, 5'b00000);
    chk("R2 bubble", bu0, 5'b00110);
    chk("R2 bubble nofwd", bu1, 5'b00110);
  endtask

  task automatic t_collide();
    clear(); mis = 1'b1; eld = 1'b1; em = 4'd4; sa = 4'd4; settle();
    chk("R3 stall", st0, 5'b00000);
    chk("R3 bubble", bu0, 5'b00110);
    chk("R4 overlap", st0 & bu0, 5'b00000);
    clear(); mis = 1'b1; wa = 4'd4; sa = 4'd4; settle();
    chk("R3 nofwd stall", st1, 5'b00000);
    chk("R4 nofwd overlap", st1 & bu1, 5'b00000);
  endtask

  task automatic t_priority();
    clear(); sa = 4'd5; ea = 4'd5; mm = 4'd5; ma = 4'd5; wm = 4'd5; wa = 4'd5; settle();
    chk("R5 exec first", {2'b0, fa0}, 5'd1);
    ea = 4'hF; settle();
    chk("R6 mem load over mem alu", {2'b0, fa0}, 5'd2);
    mm = 4'hF; settle();
    chk("R5 mem alu", {2'b0, fa0}, 5'd3);
    ma = 4'hF; settle();
    chk("R6 wb load over wb alu", {2'b0, fa0}, 5'd4);
    wm = 4'hF; settle();
    chk("R5 wb alu", {2'b0, fa0}, 5'd5);
    wa = 4'hF; settle();
    chk("R5 regfile", {2'b0, fa0}, 5'd0);
    clear(); sa = 4'd1; sb = 4'd2; ea = 4'd2; wa = 4'd1; settle();
    chk("R5 independent a", {2'b0, fa0}, 5'd5);
    chk("R5 independent b", {2'b0, fb0}, 5'd1);
    chk("R5 no stall", st0, 5'b00000);
  endtask

  task automatic t_none();
    clear(); sa = 4'hF; sb = 4'hF; eld = 1'b1; settle();
    chk("R7 stall", st0, 5'b00000);
    chk("R7 sel a", {2'b0, fa0}, 5'd0);
    chk("R7 sel b", {2'b0, fb0}, 5'd0);
    chk("R7 stall nofwd", st1, 5'b00000);
  endtask

  task automatic t_nofwd();
    clear(); sa = 4'd7; wa = 4'd7; settle();
    chk("R8 stall wb", st1, 5'b00011);
    chk("R8 bubble wb", bu1, 5'b00100);
    chk("R8 sel rf", {2'b0, fa1}, 5'd0);
    chk("R8 fwd variant no stall", st0, 5'b00000);
    clear(); sb = 4'd8; ma = 4'd8; settle();
    chk("R8 stall mem", st1, 5'b00011);
    clear(); sb = 4'd8; ea = 4'd8; settle();
    chk("R8 stall exec", st1, 5'b00011);
    chk("R8 sel b rf", {2'b0, fb1}, 5'd0);
  endtask

  initial begin
    sa = 4'hF; sb = 4'hF; ea = 4'hF; em = 4'hF; ma = 4'hF; mm = 4'hF;
    wa = 4'hF; wm = 4'hF; eld = 1'b0; mis = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    settle();
    chk("R9 reset stall", st0, 5'b00000);
    chk("R9 reset bubble", bu0, 5'b00000);
    t_idle();
    t_load_use();
    t_mispredict();
    t_collide();
    t_priority();
    t_none();
    t_nofwd();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (10000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule